// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that sits on a simple register bus. It holds a data latch and a per-pin drive-mode register, plus one global bit that turns the weak pull-ups off. For every pin it produces three pad controls: an output value, an output enable and a pull-up enable. The pad cell combines them into push-pull, open-drain or pulled-up behaviour.

Pin levels pass through a two-flop synchronizer before the bus can read them. A normal read of the data register returns those synchronized levels. When the CPU flags the read as the first half of a read-modify-write instruction, the read returns the latch instead. A bit-set or bit-clear sequence therefore never copies a pin that is being held low from outside into the latch. The latch and mode registers can still be written and read back when the pins are not bonded out.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch reads 0xFF, the mode register reads 0x00 (every pin open-drain) and the control register reads 0x00 (pull-ups enabled).
- R2: A read at address 0 with `bus_rmw` low returns `pad_in` as it was sampled two rising clock edges earlier.
- R3: A read at address 0 with `bus_rmw` high returns the data latch, whatever `pad_in` is.
- R4: A pin whose mode bit is 1 (push-pull) has `pad_oe` high and `pad_out` equal to its latch bit.
- R5: A pin whose mode bit is 0 (open-drain) and whose latch bit is 0 has `pad_oe` high and `pad_out` low.
- R6: A pin whose mode bit is 0 and whose latch bit is 1 has `pad_oe` low, so its driver is off.
- R7: Bit 0 of the control register (address 2) turns off every pull-up when it is 1. When it is 0, `pad_pu` is high on each pin that is not actively driven low.
- R8: `pad_pu` is never high on a pin where `pad_oe` is high and `pad_out` is low.
- R9: A write with `bus_we` high at address 0, 1 or 2 updates the data latch, the mode register or the control bit on the next rising edge. Bits 7:1 of address 2 and all bits of address 3 read as 0. A write to address 3 changes nothing.
- R10: The latch keeps and returns written values independently of the levels on `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 mode, 2 control, 3 reserved |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rmw | input | 1 | The current read is the read phase of a read-modify-write |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` and `bus_rmw` |
| pad_in | input | 8 | Asynchronous pin levels |
| pad_out | output | 8 | Output value per pin |
| pad_oe | output | 8 | Output driver enable per pin |
| pad_pu | output | 8 | Weak pull-up enable per pin |

## Verification
The assertions check four things on every cycle: the relation between the mode, latch and pull-up state and the three pad vectors, the rule that no pull-up is on while its pin is driven low, the latch-return path of a read-modify-write read, and the one-cycle effect of a register write. Other behaviour shows only in the bench's scenarios. These are the two-edge latency of the pin synchronizer, the reset values, mixed-mode pin patterns, the reserved address being inert, and the latch holding a value that differs from the pins.

// File: rtl/gpio_pkg.sv
// Package: shared register addresses and widths for the GPIO port.
// Assumes a 2-bit register address space on the CPU bus.
package gpio_pkg;
    localparam int unsigned ADDR_W       = 2;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_RSVD = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer that brings asynchronous pad levels into
// the clock domain. Assumes each bit is independent (no bus coherency).
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: bus-visible registers (data latch, drive mode, pull-up control)
// and the read-data multiplexer. Assumes single-cycle writes and
// combinational reads; the rmw flag selects latch over pin levels.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_rmw,
    input  logic [WIDTH-1:0]  pins_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  mode_q,
    output logic              pull_off_q
);
    logic unused_wbits;
    assign unused_wbits = &{1'b0, bus_wdata[WIDTH-1:1]};

    // Register writes; reset leaves latch high, pins open-drain, pull-ups on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q    <= '1;
            mode_q     <= '0;
            pull_off_q <= 1'b0;
        end else if (bus_we) begin
            unique case (bus_addr)
                A_DATA:  latch_q    <= bus_wdata;
                A_MODE:  mode_q     <= bus_wdata;
                A_CTRL:  pull_off_q <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Read multiplexer: pins normally, latch during a read-modify-write read.
    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = bus_rmw ? latch_q : pins_sync;
            A_MODE:  bus_rdata = mode_q;
            A_CTRL:  bus_rdata = {{(WIDTH-1){1'b0}}, pull_off_q};
            default: bus_rdata = '0;
        endcase
    end

    // R9: a data write lands in the latch on the following edge.
    assert_data_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DATA) |=> latch_q == $past(bus_wdata));
    // R9: a reserved-address write leaves all state unchanged.
    assert_rsvd_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_RSVD) |=>
            ($stable(latch_q) && $stable(mode_q) && $stable(pull_off_q)));
endmodule

// File: rtl/gpio_drive.sv
// Module: per-pin pad control. A mode bit of 1 is push-pull, 0 is
// open-drain. The pull-up is gated by the global disable and is never
// on while the pin is driven low. Assumes the pad resolves out/oe/pu.
module gpio_drive #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] mode_q,
    input  logic             pull_off_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic drive_low;
        // Driver enabled in push-pull, or in open-drain while pulling low.
        always_comb begin
            pad_out[i] = latch_q[i];
            pad_oe[i]  = mode_q[i] | ~latch_q[i];
            drive_low  = pad_oe[i] & ~latch_q[i];
            pad_pu[i]  = ~pull_off_q & ~drive_low;
        end
    end
endmodule

// File: rtl/gpio_port.sv
// Module: top of the GPIO port. It ties together the pad synchronizer,
// the bus registers and the per-pin drive logic. Assumes pad_in is
// asynchronous and the CPU asserts bus_rmw only on RMW read phases.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_rmw,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] mode_q;
    logic             pull_off_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rmw    (bus_rmw),
        .pins_sync  (pins_sync),
        .bus_rdata  (bus_rdata),
        .latch_q    (latch_q),
        .mode_q     (mode_q),
        .pull_off_q (pull_off_q)
    );

    gpio_drive #(.WIDTH(WIDTH)) i_drive (
        .latch_q    (latch_q),
        .mode_q     (mode_q),
        .pull_off_q (pull_off_q),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pu     (pad_pu)
    );

    // R3: a read-modify-write read of the data register returns the latch.
    assert_rmw_reads_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA && bus_rmw) |-> bus_rdata == latch_q);
    // R4: push-pull pins are driven with their latch value.
    assert_pushpull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & mode_q) == mode_q) && (((pad_out ^ latch_q) & mode_q) == '0));
    // R5: open-drain pins with latch 0 are driven low.
    assert_od_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~pad_out & ~mode_q & ~latch_q) == (~mode_q & ~latch_q)));
    // R6: open-drain pins with latch 1 have the driver off.
    assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~mode_q & latch_q) == '0));
    // R7: the global disable forces every pull-up off.
    assert_pull_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pull_off_q |-> pad_pu == '0);
    // R8: never pull up a pin that is being driven low.
    assert_no_pu_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe & ~pad_out) == '0);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] latch;
        logic       poff;
        logic [7:0] e_out;
        logic [7:0] e_oe;
        logic [7:0] e_pu;
    } vec_t;

    // Drive-pattern table: mode, latch, pull-off -> expected out, oe, pu.
    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{8'h00, 8'hFF, 1'b0, 8'hFF, 8'h00, 8'hFF},
        '{8'hFF, 8'hA5, 1'b0, 8'hA5, 8'hFF, 8'hA5},
        '{8'h00, 8'h3C, 1'b0, 8'h3C, 8'hC3, 8'h3C},
        '{8'hF0, 8'h5A, 1'b0, 8'h5A, 8'hF5, 8'h5A},
        '{8'h0F, 8'h00, 1'b0, 8'h00, 8'hFF, 8'h00},
        '{8'h00, 8'hFF, 1'b1, 8'hFF, 8'h00, 8'h00},
        '{8'h33, 8'h96, 1'b1, 8'h96, 8'h7B, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rmw = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] d);
        bus_addr = a; bus_rmw = rmw;
        #1 d = bus_rdata;
        bus_rmw = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        rd(2'd0, 1'b1, r); check("R1 latch reset", r, 8'hFF);
        rd(2'd1, 1'b0, r); check("R1 mode reset", r, 8'h00);
        rd(2'd2, 1'b0, r); check("R1 ctrl reset", r, 8'h00);
        check("R1 pull-ups on after reset", pad_pu, 8'hFF);

        // R4 R5 R6 R7: table of drive patterns
        for (int k = 0; k < NVEC; k++) begin
            wr(2'd1, VEC[k].mode);
            wr(2'd0, VEC[k].latch);
            wr(2'd2, {7'd0, VEC[k].poff});
            check("R4/R5 pad_out", pad_out, VEC[k].e_out);
            check("R5/R6 pad_oe", pad_oe, VEC[k].e_oe);
            check("R7/R8 pad_pu", pad_pu, VEC[k].e_pu);
        end
        wr(2'd2, 8'h00);

        // R2: two-edge synchronizer latency
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hC9;
        @(negedge clk);
        rd(2'd0, 1'b0, r); check("R2 one edge: old level", r, 8'h00);
        @(negedge clk);
        rd(2'd0, 1'b0, r); check("R2 two edges: new level", r, 8'hC9);

        // R3 R10: the latch differs from the pins
        wr(2'd0, 8'h5A);
        rd(2'd0, 1'b1, r); check("R3 rmw read returns latch", r, 8'h5A);
        rd(2'd0, 1'b0, r); check("R10 normal read returns pins", r, 8'hC9);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        rd(2'd0, 1'b1, r); check("R10 latch kept over pin change", r, 8'h5A);
        rd(2'd1, 1'b1, r); check("R3 rmw flag ignored off data addr", r, 8'h33);

        // R9: control readback, reserved address is inert
        wr(2'd2, 8'hFF);
        rd(2'd2, 1'b0, r); check("R9 ctrl upper bits read 0", r, 8'h01);
        check("R7 pull disabled", pad_pu, 8'h00);
        wr(2'd3, 8'h00);
        rd(2'd3, 1'b0, r); check("R9 rsvd reads 0", r, 8'h00);
        rd(2'd0, 1'b1, r); check("R9 rsvd write keeps latch", r, 8'h5A);
        rd(2'd1, 1'b0, r); check("R9 rsvd write keeps mode", r, 8'h33);
        rd(2'd2, 1'b0, r); check("R9 rsvd write keeps ctrl", r, 8'h01);

        // R1: reset again returns defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, 1'b1, r); check("R1 latch after second reset", r, 8'hFF);
        check("R1 oe after second reset", pad_oe, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule